// File: doc/BRIEF.md
# Clock-Alarm Transition Event Register

This block sits beside a redundant-reference clock synchronizer and turns four of its alarm levels into interrupt causes. The watched levels are primary reference lost, secondary reference lost, holdover active and loop unlocked. Each level first passes through a two-flop synchronizer. The block then compares the synchronized value with the value from the previous cycle. A change in either direction sets its own sticky flag, so each level owns two flags and the four levels fill an 8-bit cause byte.

Software reads the block through a byte-wide port. It can read the live synchronized levels, read the cause byte (this read also clears it), or read a constant that gives the interrupt line number. While any cause flag is set and the global enable is high, the block holds one level-sensitive interrupt output high.

Top module: `clkalm_evreg`

## Requirements
- R1: A 0-to-1 change of primary-lost sets cause bit 0 and a 1-to-0 change sets cause bit 1. A flag stays set until the cause byte is read.
- R2: A rising change of secondary-lost sets cause bit 2 and a falling change sets cause bit 3.
- R3: A rising change of holdover sets cause bit 4 and a falling change sets cause bit 5.
- R4: A rising change of unlock sets cause bit 6 and a falling change sets cause bit 7.
- R5: A read at address 1 returns the cause byte on `rd_data_o` one clock after the request and clears all eight flags.
- R6: If a transition is detected in the same cycle as a clearing read of the cause byte, its flag is left set. The setting of the flag wins over the clearing.
- R7: A read at address 0 returns the synchronized levels: unlock on bit 4, holdover on bit 5, secondary-lost on bit 6 and primary-lost on bit 7. Bits 3 to 0 read as zero.
- R8: A read at address 2 returns the parameter `IRQ_LINE` in bits 3 to 0 with zeros above (the value 0xF means that no block is present). A read at address 3 returns zero.
- R9: `irq_o` is high exactly when at least one cause flag is set and `irq_en_i` is high.
- R10: A synchronous active-high reset clears every cause flag, the synchronizer and history flops, `rd_data_o` and `irq_o`.
- R11: Reads at addresses 0, 2 and 3 leave the cause byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_los_i | input | 1 | Primary reference lost level (asynchronous) |
| sec_los_i | input | 1 | Secondary reference lost level (asynchronous) |
| holdover_i | input | 1 | Holdover active level (asynchronous) |
| unlock_i | input | 1 | Loop unlocked level (asynchronous) |
| irq_en_i | input | 1 | Global interrupt enable |
| rd_en_i | input | 1 | Read request strobe |
| rd_addr_i | input | 2 | Register address (0 status, 1 cause, 2 line number) |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Each level change is applied between clock edges. The matching cause flag is set at the third rising edge after the change: two edges for the synchronizer and one for the flag register. A status read shows the new level once two edges have passed. For that reason the bench waits four falling edges before it reads. Read data is registered, so each expected value goes into a queue when the request is driven. The monitor checks it one step after the edge that samples the request. For the set-wins case, the clearing read is placed so that it is sampled on the third edge after the change. The interrupt is sampled on a falling edge that comes after the flag's edge.

// File: rtl/clkalm_pkg.sv
package clkalm_pkg;

    localparam int NSRC    = 4;
    localparam int CAUSE_W = 2 * NSRC;
    localparam int DATA_W  = 8;

    // level index: 0 primary lost, 1 secondary lost, 2 holdover, 3 unlock
    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_CAUSE  = 2'd1,
        RA_IDENT  = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NSRC-1:0] fall;
        logic [NSRC-1:0] rise;
    } edge_t;

    // cause layout: even bit = rising change, odd bit = falling change
    function automatic logic [CAUSE_W-1:0] pack_cause(edge_t e);
        logic [CAUSE_W-1:0] c;
        for (int i = 0; i < NSRC; i++) begin
            c[2*i]   = e.rise[i];
            c[2*i+1] = e.fall[i];
        end
        return c;
    endfunction

    // status byte: primary on bit 7 down to unlock on bit 4
    function automatic logic [DATA_W-1:0] pack_status(logic [NSRC-1:0] lvl);
        logic [DATA_W-1:0] s;
        s = '0;
        for (int i = 0; i < NSRC; i++) begin
            s[DATA_W-1-i] = lvl[i];
        end
        return s;
    endfunction

endpackage

// File: rtl/clkalm_sync.sv
module clkalm_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assign q = sync_q;

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/clkalm_edge.sv
module clkalm_edge
    import clkalm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] cur,
    output edge_t           ev
);
    logic [NSRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_det
            assign ev.rise[g] =  cur[g] & ~prev_q[g];
            assign ev.fall[g] = ~cur[g] &  prev_q[g];
        end
    endgenerate

    // R10
    hist_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prev_q == $past(cur)));

endmodule

// File: rtl/clkalm_cause.sv
module clkalm_cause
    import clkalm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] set,
    input  logic               clr,
    output logic [CAUSE_W-1:0] q
);
    logic [CAUSE_W-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= '0;
        else if (clr) flag_q <= set;
        else          flag_q <= flag_q | set;
    end

    assign q = flag_q;

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((q & $past(q)) == $past(q)));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && (set != '0)) |=> ((q & $past(set)) == $past(set)));

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && (set == '0)) |=> (q == '0));

endmodule

// File: rtl/clkalm_evreg.sv
module clkalm_evreg
    import clkalm_pkg::*;
#(
    parameter logic [3:0] IRQ_LINE = 4'd5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pri_los_i,
    input  logic       sec_los_i,
    input  logic       holdover_i,
    input  logic       unlock_i,
    input  logic       irq_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    logic [NSRC-1:0]    lvl_raw;
    logic [NSRC-1:0]    lvl_sync;
    edge_t              ev;
    logic [CAUSE_W-1:0] cause_q;
    logic               clr_cause;
    reg_addr_e          addr;
    logic [DATA_W-1:0]  rd_q;

    assign lvl_raw = {unlock_i, holdover_i, sec_los_i, pri_los_i};
    assign addr    = reg_addr_e'(rd_addr_i);

    clkalm_sync #(.W(NSRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lvl_raw),
        .q   (lvl_sync)
    );

    clkalm_edge u_edge (
        .clk (clk),
        .rst (rst),
        .cur (lvl_sync),
        .ev  (ev)
    );

    assign clr_cause = rd_en_i && (addr == RA_CAUSE);

    clkalm_cause u_cause (
        .clk (clk),
        .rst (rst),
        .set (pack_cause(ev)),
        .clr (clr_cause),
        .q   (cause_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            unique case (addr)
                RA_STATUS: rd_q <= pack_status(lvl_sync);
                RA_CAUSE:  rd_q <= cause_q;
                RA_IDENT:  rd_q <= {4'b0000, IRQ_LINE};
                default:   rd_q <= '0;
            endcase
        end
    end

    assign rd_data_o = rd_q;
    assign irq_o     = irq_en_i && (cause_q != '0);

    // R5
    cause_read_chk: assert property (@(posedge clk) disable iff (rst)
        clr_cause |=> (rd_data_o == $past(cause_q)));

    // R8
    ident_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr == RA_IDENT) |=> (rd_data_o == {4'b0000, IRQ_LINE}));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_en_i);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ((cause_q == '0) && (rd_data_o == '0)));

endmodule

// File: tb/clkalm_evreg_bench.sv
module clkalm_evreg_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pri = 1'b0, sec = 1'b0, hold = 1'b0, unl = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    clkalm_evreg u_clkalm_evreg (
        .clk(clk), .rst(rst),
        .pri_los_i(pri), .sec_los_i(sec), .holdover_i(hold), .unlock_i(unl),
        .irq_en_i(irq_en), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data after the edge that sampled a read
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                #1;
                if (q_exp.size() > 0) begin
                    check(q_tag.pop_front(), rd_data, q_exp.pop_front());
                end
            end
        end
    end

    // driver: called at a falling edge, returns at the next one
    task automatic rd_issue(logic [1:0] a, logic [7:0] exp, string tag);
        rd_addr = a;
        rd_en   = 1'b1;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 rd_data", rd_data, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h00);
        rd_issue(2'd0, 8'h00, "R7 status after reset");
        rd_issue(2'd1, 8'h00, "R10 cause after reset");
        rd_issue(2'd2, 8'h05, "R8 ident");
        rd_issue(2'd3, 8'h00, "R8 unused addr");

        // R1 rising, interrupt disabled
        pri = 1'b1; settle();
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        rd_issue(2'd0, 8'h80, "R7 primary level");
        rd_issue(2'd1, 8'h01, "R1 primary rise");
        rd_issue(2'd1, 8'h00, "R5 cleared by read");

        // R1 falling, interrupt enabled
        irq_en = 1'b1;
        pri = 1'b0; settle();
        check("R9 irq asserted", {7'd0, irq}, 8'h01);
        rd_issue(2'd0, 8'h00, "R7 levels low");
        rd_issue(2'd1, 8'h02, "R1 primary fall");
        @(negedge clk);
        check("R9 irq after clear", {7'd0, irq}, 8'h00);

        sec = 1'b1; settle(); sec = 1'b0; settle();
        rd_issue(2'd1, 8'h0C, "R2 secondary both edges");
        hold = 1'b1; settle(); hold = 1'b0; settle();
        rd_issue(2'd1, 8'h30, "R3 holdover both edges");
        unl = 1'b1; settle(); unl = 1'b0; settle();
        rd_issue(2'd1, 8'hC0, "R4 unlock both edges");

        // all levels high
        pri = 1'b1; sec = 1'b1; hold = 1'b1; unl = 1'b1; settle();
        rd_issue(2'd0, 8'hF0, "R7 all levels");
        rd_issue(2'd2, 8'h05, "R11 ident read");
        rd_issue(2'd3, 8'h00, "R11 unused read");
        rd_issue(2'd1, 8'h55, "R11 cause kept");

        // R6: falling edge detected on the same edge as the clearing read
        pri = 1'b0;
        repeat (2) @(negedge clk);
        rd_issue(2'd1, 8'h00, "R6 read during edge");
        rd_issue(2'd1, 8'h02, "R6 flag survives clear");

        // R10: reset with flags pending
        sec = 1'b0; hold = 1'b0; unl = 1'b0; settle();
        check("R10 irq before reset", {7'd0, irq}, 8'h01);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 irq in reset", {7'd0, irq}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        rd_issue(2'd1, 8'h00, "R10 cause after reset");
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule